// File: doc/BRIEF.md
# Four-Channel DDS Register Controller

This block is the register and phase core of a four-channel direct digital synthesizer. Every channel keeps a 32-bit phase accumulator that grows by the channel's tuning word on each system clock. Because all channels share that clock, they advance in lockstep. Each channel produces two outputs. The first is its phase word, with a 14-bit phase offset added into the top bits. The second is a 10-bit amplitude word, which is either the programmed scale factor or full scale.

A host programs the block over a single-bit serial port. Each transfer is one instruction byte followed by the data bytes of one register. The per-channel registers share one address range. The channel-enable bits of the select register decide which channels take a write, and a read returns the lowest enabled channel's value. Writes land in shadow registers. The datapath only sees them after the update input has been held high for a full sync period of four system clocks. This lets a host stage changes to several channels and release them on one clock edge.

Top module: `dds_regctl`

## Requirements
- R1: Reset behaviour:
  - every accumulator, tuning word, phase offset and channel register is cleared;
  - every amplitude output reads 0x3FF;
  - the select register (address 0x00) reads back 0xF0, with all four channel enables set and mode code 00.
- R2: Each channel's phase accumulator adds its active 32-bit tuning word on every system clock and wraps modulo 2^32. The difference between phase outputs on consecutive cycles equals the tuning word.
- R3: Phase offset:
  - the phase output is the accumulator plus the active offset shifted left by 18 bits;
  - the offset is the low 14 bits of the 16-bit offset register (0x05);
  - bits 15:14 of that register do not affect the output.
- R4: The amplitude register (0x06) is 24 bits. When its bit 12 is set, the amplitude output equals bits 9:0. When bit 12 is clear, the output is 0x3FF.
- R5: Serial framing:
  - bits are sampled on rising edges of sclk while csN is low, most significant bit first;
  - the first byte is the instruction: bit 7 = 1 reads, 0 writes; bits 4:0 give the address;
  - the data length in bytes is: 0x00: 1, 0x01: 3, 0x02: 2, 0x03: 3, 0x04: 4, 0x05: 2, 0x06: 3.
- R6: Channel steering:
  - a write to 0x03–0x06 reaches exactly the channels whose enable bit is set (bit 4+n for channel n of the select register);
  - channels whose bit is clear keep their values;
  - a write to the select register itself takes effect at once.
- R7: Double buffering:
  - shadow writes never change the phase or amplitude outputs by themselves;
  - the active values reload only after ioUpdate has been sampled high on 4 consecutive clock edges;
  - a shorter high pulse does nothing.
- R8: Update timing: if ioUpdate is first sampled high at edge n and stays high through edge n+3, the new values drive the outputs from edge n+4 onward. The accumulator increment at edge n+4 still uses the old tuning word; later increments use the new one.
- R9: Reads:
  - a read returns the shadow value of the addressed register;
  - for 0x03–0x06 it returns the value of the lowest-numbered enabled channel, or zero if no channel is enabled;
  - sdo carries the value MSB first: the first bit is valid after the eighth rising edge, and each later bit after the following rising edge;
  - sdo is 0 while csN is high.
- R10: Raising csN before the last data bit of a write discards the write.
- R11: Addresses 0x07–0x1F carry one data byte. Writes to them are ignored and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; accumulators and all registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial port clock, sampled by clk |
| csN | input | 1 | Serial chip select, active low |
| sdio | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial read data |
| ioUpdate | input | 1 | Update strobe moving shadow values to active |
| phaseOut | output | NCH*32 | Per-channel phase words, channel 0 in the low bits |
| ampOut | output | NCH*10 | Per-channel amplitude words, channel 0 in the low bits |

## Verification
The reload of active registers and the accumulator step fall on the same clock edge. On that edge the accumulator must add the old tuning word, with the new word taking over one edge later. To provoke this, the bench programs a tuning word into a channel whose old word is zero and raises the update strobe at a known edge. It then records the phase on every following cycle. The phase must stay at zero through the commit edge and then rise by exactly the new word per cycle. A strobe one cycle too short is applied first and must leave the outputs untouched.

// File: rtl/dds_regctl_pkg.sv
package dds_regctl_pkg;

  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 32;
  localparam int ACC_W      = 32;
  localparam int POW_W      = 14;
  localparam int AMP_W      = 10;
  localparam int AMP_EN_BIT = 12;
  localparam int SEL_EN_LSB = 4;
  localparam int FN1_W      = 24;
  localparam int FN2_W      = 16;
  localparam int CHFN_W     = 24;
  localparam int POWREG_W   = 16;
  localparam int AMPREG_W   = 24;
  localparam logic [7:0] SEL_RESET = 8'hF0;

  localparam logic [ADDR_W-1:0] ADR_SEL  = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_FN1  = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_FN2  = 5'h02;
  localparam logic [ADDR_W-1:0] ADR_CHFN = 5'h03;
  localparam logic [ADDR_W-1:0] ADR_FTW  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_POW  = 5'h05;
  localparam logic [ADDR_W-1:0] ADR_AMP  = 5'h06;

  // control -> datapath strobes
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              commit;
  } ctlStrb_t;

  function automatic logic [2:0] regBytes(input logic [ADDR_W-1:0] a);
    case (a)
      ADR_SEL:  regBytes = 3'd1;
      ADR_FN1:  regBytes = 3'd3;
      ADR_FN2:  regBytes = 3'd2;
      ADR_CHFN: regBytes = 3'd3;
      ADR_FTW:  regBytes = 3'd4;
      ADR_POW:  regBytes = 3'd2;
      ADR_AMP:  regBytes = 3'd3;
      default:  regBytes = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/dds_serial_ctl.sv
module dds_serial_ctl
  import dds_regctl_pkg::*;
#(
  parameter int SYNC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csN,
  input  logic              sdio,
  input  logic              ioUpdate,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              sdo,
  output ctlStrb_t          strb
);

  localparam int CNT_W = $clog2(SYNC_DIV + 1);
  localparam logic [CNT_W-1:0] DIV_FULL = CNT_W'(SYNC_DIV);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(SYNC_DIV - 1);

  logic              sclkS, sclkP, sdioS, csnS;
  logic [5:0]        bitCnt;
  logic [5:0]        dataBits;
  logic              isRead;
  logic              loadRd;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] shiftIn;
  logic [DATA_W-1:0] outShift;
  logic [CNT_W-1:0]  hiCnt;

  logic              rise;
  logic [DATA_W-1:0] shiftNext;
  logic [5:0]        lastBit;

  assign rise      = sclkS & ~sclkP & ~csnS;
  assign shiftNext = {shiftIn[DATA_W-2:0], sdioS};
  assign lastBit   = 6'd7 + dataBits;
  assign rdAddr    = addrQ;
  assign sdo       = outShift[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkS    <= 1'b0;
      sclkP    <= 1'b0;
      sdioS    <= 1'b0;
      csnS     <= 1'b1;
      bitCnt   <= '0;
      dataBits <= '0;
      isRead   <= 1'b0;
      loadRd   <= 1'b0;
      addrQ    <= '0;
      shiftIn  <= '0;
      outShift <= '0;
      hiCnt    <= '0;
      strb     <= '0;
    end else begin
      sclkS       <= sclk;
      sclkP       <= sclkS;
      sdioS       <= sdio;
      csnS        <= csN;
      strb.wr     <= 1'b0;
      strb.commit <= 1'b0;
      loadRd      <= 1'b0;

      if (csnS) begin
        bitCnt   <= '0;
        isRead   <= 1'b0;
        outShift <= '0;
      end else if (loadRd) begin
        outShift <= rdData << (6'd32 - dataBits);
      end else if (rise) begin
        if (bitCnt < 6'd8) begin
          shiftIn <= shiftNext;
          bitCnt  <= bitCnt + 6'd1;
          if (bitCnt == 6'd7) begin
            isRead   <= shiftNext[7];
            loadRd   <= shiftNext[7];
            addrQ    <= shiftNext[ADDR_W-1:0];
            dataBits <= {regBytes(shiftNext[ADDR_W-1:0]), 3'b000};
          end
        end else if (bitCnt <= lastBit) begin
          bitCnt <= bitCnt + 6'd1;
          if (isRead) begin
            outShift <= outShift << 1;
          end else begin
            shiftIn <= shiftNext;
            if (bitCnt == lastBit) begin
              strb.wr   <= 1'b1;
              strb.addr <= addrQ;
              strb.data <= shiftNext;
            end
          end
        end
      end

      // update strobe must be held for one full sync period
      if (ioUpdate) begin
        if (hiCnt != DIV_FULL) hiCnt <= hiCnt + 1'b1;
        if (hiCnt == DIV_LAST) strb.commit <= 1'b1;
      end else begin
        hiCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/dds_chan_bank.sv
module dds_chan_bank
  import dds_regctl_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctlStrb_t             strb,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic [NCH*ACC_W-1:0] phaseOut,
  output logic [NCH*AMP_W-1:0] ampOut
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [7:0]            selReg;
  logic [FN1_W-1:0]      fn1Sh;
  logic [FN2_W-1:0]      fn2Sh;
  logic [NCH*DATA_W-1:0] chRdFlat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selReg <= SEL_RESET;
      fn1Sh  <= '0;
      fn2Sh  <= '0;
    end else if (strb.wr) begin
      case (strb.addr)
        ADR_SEL: selReg <= strb.data[7:0];
        ADR_FN1: fn1Sh  <= strb.data[FN1_W-1:0];
        ADR_FN2: fn2Sh  <= strb.data[FN2_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : gCh
    logic [CHFN_W-1:0]   cfrSh;
    logic [ACC_W-1:0]    ftwSh;
    logic [POWREG_W-1:0] powSh;
    logic [AMPREG_W-1:0] ampSh;
    logic [ACC_W-1:0]    ftwAc;
    logic [POW_W-1:0]    powAc;
    logic                ampEnAc;
    logic [AMP_W-1:0]    ampScAc;
    logic [ACC_W-1:0]    acc;
    logic                chHit;
    logic [DATA_W-1:0]   chRd;

    assign chHit = strb.wr & selReg[SEL_EN_LSB+ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfrSh   <= '0;
        ftwSh   <= '0;
        powSh   <= '0;
        ampSh   <= '0;
        ftwAc   <= '0;
        powAc   <= '0;
        ampEnAc <= 1'b0;
        ampScAc <= '0;
        acc     <= '0;
      end else begin
        if (chHit) begin
          case (strb.addr)
            ADR_CHFN: cfrSh <= strb.data[CHFN_W-1:0];
            ADR_FTW:  ftwSh <= strb.data[ACC_W-1:0];
            ADR_POW:  powSh <= strb.data[POWREG_W-1:0];
            ADR_AMP:  ampSh <= strb.data[AMPREG_W-1:0];
            default: ;
          endcase
        end
        if (strb.commit) begin
          ftwAc   <= ftwSh;
          powAc   <= powSh[POW_W-1:0];
          ampEnAc <= ampSh[AMP_EN_BIT];
          ampScAc <= ampSh[AMP_W-1:0];
        end
        acc <= acc + ftwAc;
      end
    end

    assign phaseOut[ch*ACC_W +: ACC_W] = acc + {powAc, {(ACC_W-POW_W){1'b0}}};
    assign ampOut[ch*AMP_W +: AMP_W]   = ampEnAc ? ampScAc : {AMP_W{1'b1}};

    always_comb begin
      case (rdAddr)
        ADR_CHFN: chRd = DATA_W'(cfrSh);
        ADR_FTW:  chRd = DATA_W'(ftwSh);
        ADR_POW:  chRd = DATA_W'(powSh);
        ADR_AMP:  chRd = DATA_W'(ampSh);
        default:  chRd = '0;
      endcase
    end

    assign chRdFlat[ch*DATA_W +: DATA_W] = chRd;
  end

  logic            hitAny;
  logic [CH_W-1:0] pick;
  logic [DATA_W-1:0] chosen;

  always_comb begin
    hitAny = 1'b0;
    pick   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (selReg[SEL_EN_LSB+i]) begin
        hitAny = 1'b1;
        pick   = CH_W'(i);
      end
    end
    chosen = chRdFlat[int'(pick)*DATA_W +: DATA_W];
    case (rdAddr)
      ADR_SEL:  rdData = DATA_W'(selReg);
      ADR_FN1:  rdData = DATA_W'(fn1Sh);
      ADR_FN2:  rdData = DATA_W'(fn2Sh);
      ADR_CHFN, ADR_FTW, ADR_POW, ADR_AMP:
                rdData = hitAny ? chosen : '0;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/dds_regctl.sv
module dds_regctl
  import dds_regctl_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int SYNC_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 csN,
  input  logic                 sdio,
  output logic                 sdo,
  input  logic                 ioUpdate,
  output logic [NCH*ACC_W-1:0] phaseOut,
  output logic [NCH*AMP_W-1:0] ampOut
);

  ctlStrb_t          strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;

  dds_serial_ctl #(.SYNC_DIV(SYNC_DIV)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .csN      (csN),
    .sdio     (sdio),
    .ioUpdate (ioUpdate),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .sdo      (sdo),
    .strb     (strb)
  );

  dds_chan_bank #(.NCH(NCH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .phaseOut (phaseOut),
    .ampOut   (ampOut)
  );

endmodule

// File: rtl/dds_regctl_chk.sv
module dds_regctl_chk #(
  parameter int NCH      = 4,
  parameter int SYNC_DIV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csN,
  input logic              ioUpdate,
  input logic              sdo,
  input logic [NCH*10-1:0] ampOut,
  input logic              commit
);

  // run length of consecutive high update samples, saturating
  logic [7:0] hiRun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hiRun <= '0;
    else if (!ioUpdate)         hiRun <= '0;
    else if (hiRun != 8'hFF)    hiRun <= hiRun + 8'd1;
  end

  // R7: outputs move only on the cycle after a commit
  p_amp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(ampOut));

  // R7: one reload per high period
  p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R8: a reload needs a full sync period of high strobe
  p_commit_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (int'(hiRun) >= SYNC_DIV));

  // R9: read line idles low while deselected
  p_sdo_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csN && $past(csN) && $past(csN, 2)) |-> !sdo);

endmodule

bind dds_regctl dds_regctl_chk #(.NCH(NCH), .SYNC_DIV(SYNC_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csN      (csN),
  .ioUpdate (ioUpdate),
  .sdo      (sdo),
  .ampOut   (ampOut),
  .commit   (strb.commit)
);

// File: tb/dds_regctl_tb.sv
`timescale 1ns/1ps
module dds_regctl_tb;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdio = 1'b0;
  logic ioUpdate = 1'b0;
  logic sdo;
  logic [NCH*32-1:0] phaseOut;
  logic [NCH*10-1:0] ampOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dds_regctl #(.NCH(NCH), .SYNC_DIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csN(csN), .sdio(sdio),
    .sdo(sdo), .ioUpdate(ioUpdate), .phaseOut(phaseOut), .ampOut(ampOut)
  );

  function automatic logic [31:0] ph(input int ch);
    return phaseOut[ch*32 +: 32];
  endfunction

  function automatic logic [31:0] am(input int ch);
    return 32'(ampOut[ch*10 +: 10]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic xfer(input logic b, output logic o);
    @(negedge clk);
    sclk = 1'b0;
    sdio = b;
    repeat (3) @(negedge clk);
    o = sdo;
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic csLow();
    @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d, input int nb);
    logic o;
    logic [7:0] ins;
    ins = {3'b000, a};
    csLow();
    for (int i = 7; i >= 0; i--) xfer(ins[i], o);
    for (int i = nb*8-1; i >= 0; i--) xfer(d[i], o);
    csHigh();
  endtask

  task automatic readReg(input logic [4:0] a, input int nb, output logic [31:0] d);
    logic o;
    logic [7:0] ins;
    ins = {3'b100, a};
    d = '0;
    csLow();
    for (int i = 7; i >= 0; i--) xfer(ins[i], o);
    for (int i = nb*8-1; i >= 0; i--) begin
      xfer(1'b0, o);
      d[i] = o;
    end
    csHigh();
  endtask

  task automatic pulseUpd(input int n);
    @(negedge clk);
    ioUpdate = 1'b1;
    repeat (n) @(negedge clk);
    ioUpdate = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // R1: reset state
  task automatic testReset();
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      chk("R1 phase after reset", ph(c), 32'h0);
      chk("R1 amplitude after reset", am(c), 32'h3FF);
    end
    readReg(5'h00, 1, d);
    chk("R1 select reset value", d, 32'h0000_00F0);
  endtask

  // R5 framing, R9 global readback, R6 select immediate
  task automatic testFraming();
    logic [31:0] d;
    writeReg(5'h01, 32'h00AB_CDEF, 3);
    readReg(5'h01, 3, d);
    chk("R5 three-byte register readback", d, 32'h00AB_CDEF);
    writeReg(5'h02, 32'h0000_1234, 2);
    readReg(5'h02, 2, d);
    chk("R9 two-byte register readback", d, 32'h0000_1234);
    writeReg(5'h00, 32'h0000_00F6, 1);
    readReg(5'h00, 1, d);
    chk("R6 select write immediate", d, 32'h0000_00F6);
    writeReg(5'h00, 32'h0000_0020, 1);
  endtask

  // R7 buffering and R8 commit edge against the accumulator step
  task automatic testCommit();
    logic [31:0] p [9];
    writeReg(5'h04, 32'h0000_0100, 4);
    repeat (10) @(negedge clk);
    chk("R7 shadow write leaves phase", ph(1), 32'h0);
    pulseUpd(3);
    repeat (10) @(negedge clk);
    chk("R7 short strobe ignored", ph(1), 32'h0);
    @(negedge clk);
    ioUpdate = 1'b1;
    p[0] = ph(1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 4) ioUpdate = 1'b0;
      p[k] = ph(1);
    end
    chk("R8 phase before strobe", p[0], 32'h0);
    chk("R8 commit edge uses old word", p[5], 32'h0);
    chk("R8 first step with new word", p[6], 32'h100);
    chk("R8 third step with new word", p[8], 32'h300);
  endtask

  // R2 wrap and R6 unselected channel untouched
  task automatic testWrap();
    logic [31:0] a, b;
    writeReg(5'h00, 32'h0000_0080, 1);
    writeReg(5'h04, 32'hC000_0000, 4);
    pulseUpd(4);
    a = ph(3);
    @(negedge clk);
    b = ph(3);
    chk("R2 step wraps modulo 2^32", b - a, 32'hC000_0000);
    chk("R6 unselected channel keeps phase", ph(2), 32'h0);
  endtask

  // R3 phase offset and masking of upper bits
  task automatic testOffset();
    writeReg(5'h00, 32'h0000_0040, 1);
    writeReg(5'h05, 32'h0000_C001, 2);
    pulseUpd(4);
    chk("R3 offset upper bits ignored", ph(2), 32'h0004_0000);
    writeReg(5'h05, 32'h0000_2000, 2);
    pulseUpd(4);
    chk("R3 half-turn offset", ph(2), 32'h8000_0000);
  endtask

  // R4 amplitude scaling and bypass
  task automatic testAmp();
    writeReg(5'h00, 32'h0000_0010, 1);
    writeReg(5'h06, 32'h0000_1155, 3);
    repeat (6) @(negedge clk);
    chk("R7 amplitude waits for strobe", am(0), 32'h3FF);
    pulseUpd(4);
    chk("R4 scale enabled", am(0), 32'h155);
    writeReg(5'h06, 32'h0000_0155, 3);
    pulseUpd(4);
    chk("R4 scale disabled gives full scale", am(0), 32'h3FF);
  endtask

  // R6 multi-channel write and R9 read selection
  task automatic testSteer();
    logic [31:0] d;
    writeReg(5'h00, 32'h0000_0030, 1);
    writeReg(5'h03, 32'h0000_ABCD, 3);
    writeReg(5'h00, 32'h0000_0020, 1);
    readReg(5'h03, 3, d);
    chk("R6 second enabled channel written", d, 32'h0000_ABCD);
    writeReg(5'h00, 32'h0000_0040, 1);
    readReg(5'h03, 3, d);
    chk("R6 disabled channel not written", d, 32'h0);
    writeReg(5'h00, 32'h0000_0030, 1);
    readReg(5'h04, 4, d);
    chk("R9 lowest enabled channel read", d, 32'h0);
    writeReg(5'h00, 32'h0000_0020, 1);
    readReg(5'h04, 4, d);
    chk("R9 channel one word", d, 32'h0000_0100);
    writeReg(5'h00, 32'h0000_0000, 1);
    readReg(5'h04, 4, d);
    chk("R9 no channel enabled reads zero", d, 32'h0);
    writeReg(5'h00, 32'h0000_0020, 1);
  endtask

  // R10 aborted write
  task automatic testAbort();
    logic [31:0] d;
    logic o;
    logic [7:0] ins;
    ins = 8'h04;
    csLow();
    for (int i = 7; i >= 0; i--) xfer(ins[i], o);
    for (int i = 0; i < 12; i++) xfer(1'b1, o);
    csHigh();
    readReg(5'h04, 4, d);
    chk("R10 aborted write discarded", d, 32'h0000_0100);
  endtask

  // R11 unmapped address
  task automatic testUnmapped();
    logic [31:0] d;
    writeReg(5'h09, 32'h0000_00FF, 1);
    readReg(5'h09, 1, d);
    chk("R11 unmapped reads zero", d, 32'h0);
    readReg(5'h00, 1, d);
    chk("R11 unmapped write leaves select", d, 32'h0000_0020);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testFraming();
    testCommit();
    testWrap();
    testOffset();
    testAmp();
    testSteer();
    testAbort();
    testUnmapped();
    finishRun();
  end

endmodule